// File: doc/BRIEF.md
# Seconds Real-Time Clock with Alarm

This block is a real-time clock core that runs in a slow clock domain, normally 32.768 kHz. A programmable divider turns that clock into a once-per-second tick. The tick advances a 32-bit seconds count and raises a sticky "second elapsed" flag. A 32-bit alarm register is compared against the seconds count and raises a sticky alarm flag on a match. Each flag has its own interrupt enable, and the enabled flags are combined into one interrupt line.

The divider rate can be trimmed. An adjustment field N makes one second in every N+1 last one clock longer, so the crystal error can be corrected in fine steps. The divider and adjustment fields sit behind a lock bit. While the lock bit is set, software cannot change them.

Software reaches the block through a flat register port. The port has a 2-bit word address, a one-cycle write strobe and a combinational read mux:
- address 0 is control;
- address 1 is seconds;
- address 2 is alarm;
- address 3 is the regulator.

Top module: `secs_rtc`

## Requirements
- R1: After reset the registers read as follows: control reads 0x0000_0080, seconds reads 0, alarm reads 0 and the regulator reads 0x0000_7FFF. Bit 7 of control (write ready) always reads 1, and bit 1 reads 0.
- R2: Seconds (address 1) and alarm (address 2) are full 32-bit registers that read back exactly what was last written.
- R3: Control bit 0 enables counting. With a divider value D (regulator bits 15:0) and no trim, `tick` pulses for one cycle every D+1 clocks. The seconds count increments on the clock edge that ends each pulse.
- R4: Regulator bits 25:16 hold the adjustment value A. Take the seconds counted since the last seconds write, starting at k=0. When A is nonzero, second k lasts D+2 clocks if k mod (A+1) equals A, and D+1 clocks otherwise. When A is zero, every second lasts D+1 clocks.
- R5: A write to seconds loads the value and restarts both the divider phase and the adjustment sequence. After the write the first tick comes D clocks later.
- R6: While control bit 0 is clear, no tick occurs and the seconds count holds its value.
- R7: Regulator bit 31 is the lock bit, and it is always writable. While it is set, a regulator write leaves the divider and adjustment fields unchanged.
- R8: Control bit 6 is the 1 Hz flag, and every tick sets it. A control write with 0 in bit 6 clears the flag, and a write with 1 leaves it unchanged.
- R9: Control bit 2 enables the alarm. While bit 2 is set and seconds equals alarm, the alarm flag (control bit 4) is set on each clock. A write with 0 in bit 4 clears the flag, and a write with 1 leaves it unchanged.
- R10: `irq` equals (bit 4 AND bit 3) OR (bit 6 AND bit 5) of control.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow clock of the clock domain |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 2 | Register word address |
| wr_en | input | 1 | Write strobe for one cycle |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data of the addressed register |
| tick | output | 1 | One-cycle pulse at the end of each second |
| irq | output | 1 | Combined interrupt |

## Verification
The divider is swept over several small reload values, each combined with several adjustment values, including zero. The time of every tick is compared with a running sum of second lengths computed from D and A. This sweep separates an off-by-one error in the reload from a stretch applied to the wrong second or at the wrong spacing. Lock sequences check each ordering of lock, write and unlock. Flag writes with ones and with zeros check that a flag is kept or cleared correctly. An alarm approached one second at a time shows that the flag stays low at the second before the match and is set at the match.

// File: rtl/secs_rtc.sv
module secs_rtc #(
  parameter int SECW    = 32,
  parameter int DIVW    = 16,
  parameter int ADJW    = 10,
  parameter int DIV_RST = 32767
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  addr,
  input  logic        wr_en,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        tick,
  output logic        irq
);
  localparam int ADJ_LSB  = 16;
  localparam int LOCK_BIT = 31;

  logic            ctl_en, alm_en, alm_ie, alm_f, hz_ie, hz_f;
  logic [DIVW-1:0] div_q;
  logic [ADJW-1:0] adj_q, acnt_q;
  logic            lock_q;
  logic [SECW-1:0] secs_q, alarm_q;
  logic [DIVW:0]   cnt_q, limit;
  logic            stretch, match;
  logic            wr_ctl, wr_secs, wr_alm, wr_reg;

  assign wr_ctl  = wr_en && addr == 2'd0;
  assign wr_secs = wr_en && addr == 2'd1;
  assign wr_alm  = wr_en && addr == 2'd2;
  assign wr_reg  = wr_en && addr == 2'd3;

  assign stretch = (adj_q != '0) && (acnt_q == adj_q);
  assign limit   = {1'b0, div_q} + {{DIVW{1'b0}}, stretch};
  assign tick    = ctl_en && (cnt_q >= limit);
  assign match   = alm_en && (secs_q == alarm_q);
  assign irq     = (alm_f && alm_ie) || (hz_f && hz_ie);

  always_comb begin
    rdata = '0;
    case (addr)
      2'd0: rdata[7:0] = {1'b1, hz_f, hz_ie, alm_f, alm_ie, alm_en, 1'b0, ctl_en};
      2'd1: rdata[SECW-1:0] = secs_q;
      2'd2: rdata[SECW-1:0] = alarm_q;
      default: begin
        rdata[LOCK_BIT] = lock_q;
        rdata[ADJ_LSB +: ADJW] = adj_q;
        rdata[DIVW-1:0] = div_q;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_en <= 1'b0;
      alm_en <= 1'b0;
      alm_ie <= 1'b0;
      hz_ie  <= 1'b0;
      alm_f  <= 1'b0;
      hz_f   <= 1'b0;
    end else begin
      if (wr_ctl) begin
        ctl_en <= wdata[0];
        alm_en <= wdata[2];
        alm_ie <= wdata[3];
        hz_ie  <= wdata[5];
      end
      alm_f <= (wr_ctl ? (alm_f && wdata[4]) : alm_f) || match;
      hz_f  <= (wr_ctl ? (hz_f && wdata[6]) : hz_f) || tick;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      secs_q <= '0;
      cnt_q  <= '0;
      acnt_q <= '0;
    end else if (wr_secs) begin
      secs_q <= wdata[SECW-1:0];
      cnt_q  <= '0;
      acnt_q <= '0;
    end else if (tick) begin
      secs_q <= secs_q + 1'b1;
      cnt_q  <= '0;
      acnt_q <= stretch ? '0 : acnt_q + 1'b1;
    end else if (ctl_en) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) alarm_q <= '0;
    else if (wr_alm) alarm_q <= wdata[SECW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= 1'b0;
      div_q  <= DIVW'(DIV_RST);
      adj_q  <= '0;
    end else if (wr_reg) begin
      lock_q <= wdata[LOCK_BIT];
      if (!lock_q) begin
        div_q <= wdata[DIVW-1:0];
        adj_q <= wdata[ADJ_LSB +: ADJW];
      end
    end
  end

  assert_secs_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr_secs) |=> secs_q == $past(secs_q) + 1'b1);
  assert_hold_when_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_en && !wr_secs) |=> $stable(secs_q));
  assert_locked_fields_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_reg && lock_q) |=> ($stable(div_q) && $stable(adj_q)));
  assert_hz_flag_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> hz_f);
  assert_hz_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (hz_f && !(wr_ctl && !wdata[6])) |=> hz_f);
  assert_alarm_flag_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> alm_f);
  assert_irq_alarm_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata[4] && rdata[3] && addr == 2'd0) |-> irq);
endmodule

// File: tb/tb_secs_rtc.sv
module tb_secs_rtc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic        wr_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        tick, irq;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  secs_rtc dut (.clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
                .wdata(wdata), .rdata(rdata), .tick(tick), .irq(irq));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  initial begin
    #200000;
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    peek(0, v); chk(v == 32'h80, "R1 ctrl", v, 32'h80);
    peek(1, v); chk(v == 0, "R1 secs", v, 0);
    peek(2, v); chk(v == 0, "R1 alarm", v, 0);
    peek(3, v); chk(v == 32'h7FFF, "R1 reg", v, 32'h7FFF);
    chk(irq == 0, "R1 irq", {31'b0, irq}, 0);

    wr(1, 32'hDEADBEEF); peek(1, v); chk(v == 32'hDEADBEEF, "R2 secs", v, 32'hDEADBEEF);
    wr(2, 32'h12345678); peek(2, v); chk(v == 32'h12345678, "R2 alarm", v, 32'h12345678);

    // R6: disabled, nothing moves
    begin
      bit seen = 0;
      addr = 1;
      repeat (40) begin @(negedge clk); if (tick) seen = 1; end
      chk(!seen, "R6 no tick", {31'b0, seen}, 0);
      peek(1, v); chk(v == 32'hDEADBEEF, "R6 secs hold", v, 32'hDEADBEEF);
    end

    // R3/R4/R5 sweep
    for (int d = 1; d <= 5; d++) begin
      for (int a = 0; a <= 3; a++) begin
        int t, k, expk;
        wr(0, 32'h40);
        wr(3, (a << 16) | d);
        wr(1, 0);
        wr(0, 32'h41);
        addr = 1;
        t = 0; k = 0; expk = d;
        while (k < 9 && t < 400) begin
          @(negedge clk);
          t++;
          if (tick || t == expk) begin
            #1;
            chk(tick && t == expk, (a == 0) ? "R3 tick time" : "R4 trimmed tick time", t, expk);
            chk(rdata == k, "R5 secs at tick", rdata, k);
            k++;
            expk += d + 1 + ((a != 0 && (k % (a + 1)) == a) ? 1 : 0);
          end
        end
        chk(k == 9, "R3 tick count", k, 9);
      end
    end

    // R8 flag handling
    wr(0, 32'h40);
    peek(0, v); chk(v == 32'hC0, "R8 flag kept by 1", v, 32'hC0);
    chk(irq == 0, "R10 irq masked", {31'b0, irq}, 0);
    wr(0, 32'h60);
    chk(irq == 1, "R10 irq hz", {31'b0, irq}, 1);
    wr(0, 32'h20);
    peek(0, v); chk(v == 32'hA0, "R8 flag cleared by 0", v, 32'hA0);
    chk(irq == 0, "R10 irq after clear", {31'b0, irq}, 0);

    // R7 lock
    wr(3, 32'h8000_0005); peek(3, v); chk(v == 32'h8000_0005, "R7 lock set", v, 32'h8000_0005);
    wr(3, 32'h8003_0009); peek(3, v); chk(v == 32'h8000_0005, "R7 locked write", v, 32'h8000_0005);
    wr(3, 32'h0002_0009); peek(3, v); chk(v == 32'h0000_0005, "R7 unlock only", v, 32'h0000_0005);
    wr(3, 32'h0002_0009); peek(3, v); chk(v == 32'h0002_0009, "R7 unlocked write", v, 32'h0002_0009);

    // R9 alarm
    wr(3, 32'h1);
    wr(2, 5);
    wr(1, 3);
    wr(0, 32'h0D);
    begin
      int guard = 0;
      do begin @(negedge clk); peek(1, v); guard++; end while (v != 4 && guard < 50);
      peek(0, v); chk(v[4] == 0, "R9 no flag before match", v, 32'h8D);
      do begin @(negedge clk); peek(1, v); guard++; end while (v != 5 && guard < 50);
      @(negedge clk);
      peek(0, v); chk(v[4] == 1, "R9 flag at match", v, 32'h9D);
      chk(irq == 1, "R10 irq alarm", {31'b0, irq}, 1);
      wr(0, 32'h1C);
      peek(0, v); chk(v[4] == 1 && v[0] == 0, "R9 flag kept by 1", v, 32'h9C);
      wr(1, 0);
      wr(0, 32'h08);
      peek(0, v); chk(v[4] == 0, "R9 flag cleared by 0", v, 32'h88);
      chk(irq == 0, "R10 irq cleared", {31'b0, irq}, 0);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule